// File: doc/BRIEF.md
# Nested Core Event Controller

This block collects sixteen event requests, remembers each one in a latch register, filters them with a per-event enable mask and picks one event to present to the processor. The highest-priority candidate is offered only if it outranks every event that is already being serviced. The processor takes the offered event with an accept strobe and finishes its service with a return strobe. The block keeps a pending register of active and nested events from these two strobes.

Software reaches the three sixteen-bit registers (latch, mask, pending) through a small register port. Every write needs the privilege input. The pending register can only be read. A latch bit can be written only while its event is masked. A global enable flag has separate set and clear strobes. It gates only the upper, general-purpose part of the event range. The lower events are never gated by it.

Top module: `nec_core`

## Requirements
- R1: After reset the latch, mask and pending registers read zero, the global enable flag is set and no request is presented.
- R2: An event input that is high at a clock edge sets its latch bit. The bit stays set after the input falls, until it is accepted or written.
- R3: Register address 0 is the latch register. A privileged write there changes only the bits whose mask bit is 0. Bits with mask bit 1 keep their value, and a capture in the same cycle still sets its bit.
- R4: Register address 1 is the mask register and changes only on a privileged write. Address 2 is the pending register, and writes to it have no effect. Address 3 reads zero. A write with the privilege input low changes no register.
- R5: An event is offered (irq_req high, irq_id its number) only when its latch and mask bits are both 1. An event that is latched but masked stays latched and is not offered.
- R6: Among the offered candidates the lowest event number wins.
- R7: A candidate is offered only if its number is strictly lower than the lowest-numbered set pending bit. With pending zero, any candidate may be offered.
- R8: An accept (irq_ack while irq_req is high) sets the offered event's pending bit and clears its latch bit at the same edge. The clear wins over a capture of that event in the same cycle. An accept while irq_req is low has no effect.
- R9: A return strobe clears the lowest-numbered set pending bit. An accept in the same cycle then sets its own bit.
- R10: While the global enable flag is 0, events 7 to 15 are not offered. Events 0 to 6 are not affected. The clear strobe sets the flag to 0 and the set strobe sets it to 1. If both strobes arrive together, the clear strobe wins. Latching goes on regardless of the flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ev_in | input | 16 | Event request levels, bit n is event n |
| irq_req | output | 1 | An event is offered to the processor |
| irq_id | output | 4 | Number of the offered event |
| irq_ack | input | 1 | Processor accepts the offered event |
| irq_ret | input | 1 | Processor returns from the current service level |
| gie_on | input | 1 | Strobe that enables the general-purpose events |
| gie_off | input | 1 | Strobe that disables the general-purpose events |
| priv | input | 1 | Privilege level; must be high for any register write |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register select: 0 latch, 1 mask, 2 pending, 3 none |
| reg_wdata | input | 16 | Register write data |
| reg_rdata | output | 16 | Register read data for reg_addr |

## Verification
Directed sequences first raise a single event, which separates latching from dispatch, and then two events at once, which separates the priority order from arrival order. A lower-numbered event then arrives during service and is offered, while a higher-numbered event waits. This shows that nesting is decided against the pending register and not against the latch. Further sequences write the latch under partial masks, toggle the global flag around events on both sides of event 7, and accept an event whose input is still high. A long stretch of sparse random events, strobes and writes follows, compared every cycle against a behavioural model. It mixes returns with accepts in the same cycle, which the directed part does not reach.

// File: rtl/nec_pkg.sv
// Shared definitions for the nested core event controller.
// Assumes a two-bit register select on the register port.
package nec_pkg;
    typedef enum logic [1:0] {
        RA_LATCH = 2'd0,
        RA_MASK  = 2'd1,
        RA_PEND  = 2'd2,
        RA_NONE  = 2'd3
    } reg_sel_e;
endpackage

// File: rtl/nec_prio_find.sv
// Finds the lowest-numbered set bit of a vector (lowest number = highest priority).
// Purely combinational; idx is zero when found is low.
module nec_prio_find #(
    parameter int W  = 16,
    parameter int IW = $clog2(W)
) (
    input  logic [W-1:0]  vec,
    output logic          found,
    output logic [IW-1:0] idx
);
    // scan from the top down so the lowest set bit is the last one written
    always_comb begin
        found = 1'b0;
        idx   = '0;
        for (int i = W - 1; i >= 0; i--) begin
            if (vec[i]) begin
                found = 1'b1;
                idx   = IW'(i);
            end
        end
    end
endmodule

// File: rtl/nec_latch_bank.sv
// Per-event latch register. Each bit is cleared by accept, set by capture,
// or else loaded by a software write while the bit is masked off.
// Assumes clr has at most one bit set and only on an unmasked event.
module nec_latch_bank #(
    parameter int N = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] cap,
    input  logic [N-1:0] clr,
    input  logic         wr_en,
    input  logic [N-1:0] wr_data,
    input  logic [N-1:0] msk,
    output logic [N-1:0] lat_q
);
    for (genvar g = 0; g < N; g++) begin : g_bit
        // one latch bit: clear has priority over capture, capture over write
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                lat_q[g] <= 1'b0;
            end else if (clr[g]) begin
                lat_q[g] <= 1'b0;
            end else if (cap[g]) begin
                lat_q[g] <= 1'b1;
            end else if (wr_en && !msk[g]) begin
                lat_q[g] <= wr_data[g];
            end
        end
    end
endmodule

// File: rtl/nec_nest_tracker.sv
// Pending (nesting) register. An accept sets one bit, a return clears the
// lowest-numbered set bit. Also reports the active top level.
// Assumes set_en only on a valid accept of an event numbered below the top level.
module nec_nest_tracker #(
    parameter int N  = 16,
    parameter int IW = $clog2(N)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          set_en,
    input  logic [IW-1:0] set_idx,
    input  logic          ret,
    output logic [N-1:0]  pnd_q,
    output logic          top_found,
    output logic [IW-1:0] top_idx
);
    logic [N-1:0] ret_clr;
    logic [N-1:0] acc_set;

    nec_prio_find #(.W(N), .IW(IW)) u_top (
        .vec   (pnd_q),
        .found (top_found),
        .idx   (top_idx)
    );

    // decode the bits touched by return and accept
    always_comb begin
        ret_clr = (ret && top_found) ? (N'(1) << top_idx) : '0;
        acc_set = set_en ? (N'(1) << set_idx) : '0;
    end

    // pending update: return clears the old top first, accept then sets
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pnd_q <= '0;
        end else begin
            pnd_q <= (pnd_q & ~ret_clr) | acc_set;
        end
    end
endmodule

// File: rtl/nec_dispatch.sv
// Chooses the event to offer: latched, unmasked, allowed by the global flag,
// and numbered strictly below the active top level. Combinational.
module nec_dispatch #(
    parameter int N     = 16,
    parameter int IW    = $clog2(N),
    parameter int GP_LO = 7
) (
    input  logic [N-1:0]  lat,
    input  logic [N-1:0]  msk,
    input  logic          gie,
    input  logic          top_found,
    input  logic [IW-1:0] top_idx,
    output logic          req,
    output logic [IW-1:0] id
);
    logic [N-1:0]  gate;
    logic [N-1:0]  cand;
    logic          c_found;
    logic [IW-1:0] c_idx;

    for (genvar g = 0; g < N; g++) begin : g_gate
        if (g < GP_LO) begin : g_core
            assign gate[g] = 1'b1;
        end else begin : g_gp
            assign gate[g] = gie;
        end
    end

    // candidates are latched, enabled and not globally gated
    always_comb cand = lat & msk & gate;

    nec_prio_find #(.W(N), .IW(IW)) u_cand (
        .vec   (cand),
        .found (c_found),
        .idx   (c_idx)
    );

    // offer the winner only if it outranks the active level
    always_comb begin
        req = c_found && (!top_found || (c_idx < top_idx));
        id  = c_idx;
    end
endmodule

// File: rtl/nec_core.sv
// Nested core event controller top. Latches events, masks them, offers the
// winning event and tracks nesting through accept and return strobes.
// Assumes the processor raises irq_ack only for the event shown on irq_id.
module nec_core #(
    parameter int N_EV  = 16,
    parameter int GP_LO = 7,
    localparam int IW   = $clog2(N_EV)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [N_EV-1:0] ev_in,
    output logic            irq_req,
    output logic [IW-1:0]   irq_id,
    input  logic            irq_ack,
    input  logic            irq_ret,
    input  logic            gie_on,
    input  logic            gie_off,
    input  logic            priv,
    input  logic            reg_we,
    input  logic [1:0]      reg_addr,
    input  logic [N_EV-1:0] reg_wdata,
    output logic [N_EV-1:0] reg_rdata
);
    import nec_pkg::*;

    logic [N_EV-1:0] lat_q;
    logic [N_EV-1:0] msk_q;
    logic [N_EV-1:0] pnd_q;
    logic            gie_q;
    logic            acc;
    logic [N_EV-1:0] acc_clr;
    logic            lat_we;
    logic            msk_we;
    logic            top_found;
    logic [IW-1:0]   top_idx;
    reg_sel_e        sel;

    // decode accept and privileged writes
    always_comb begin
        sel     = reg_sel_e'(reg_addr);
        acc     = irq_ack && irq_req;
        acc_clr = acc ? (N_EV'(1) << irq_id) : '0;
        lat_we  = reg_we && priv && (sel == RA_LATCH);
        msk_we  = reg_we && priv && (sel == RA_MASK);
    end

    nec_latch_bank #(.N(N_EV)) u_lat (
        .clk     (clk),
        .rst_n   (rst_n),
        .cap     (ev_in),
        .clr     (acc_clr),
        .wr_en   (lat_we),
        .wr_data (reg_wdata),
        .msk     (msk_q),
        .lat_q   (lat_q)
    );

    nec_nest_tracker #(.N(N_EV), .IW(IW)) u_nest (
        .clk       (clk),
        .rst_n     (rst_n),
        .set_en    (acc),
        .set_idx   (irq_id),
        .ret       (irq_ret),
        .pnd_q     (pnd_q),
        .top_found (top_found),
        .top_idx   (top_idx)
    );

    nec_dispatch #(.N(N_EV), .IW(IW), .GP_LO(GP_LO)) u_disp (
        .lat       (lat_q),
        .msk       (msk_q),
        .gie       (gie_q),
        .top_found (top_found),
        .top_idx   (top_idx),
        .req       (irq_req),
        .id        (irq_id)
    );

    // mask register, written only with privilege
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            msk_q <= '0;
        end else if (msk_we) begin
            msk_q <= reg_wdata;
        end
    end

    // global enable flag for the general-purpose range; clear wins
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            gie_q <= 1'b1;
        end else if (gie_off) begin
            gie_q <= 1'b0;
        end else if (gie_on) begin
            gie_q <= 1'b1;
        end
    end

    // register read mux
    always_comb begin
        unique case (sel)
            RA_LATCH: reg_rdata = lat_q;
            RA_MASK:  reg_rdata = msk_q;
            RA_PEND:  reg_rdata = pnd_q;
            default:  reg_rdata = '0;
        endcase
    end
endmodule

// File: rtl/nec_core_chk.sv
// Property checker for nec_core, attached by bind. Observes ports and the
// three registers plus the global flag.
module nec_core_chk #(
    parameter int N_EV  = 16,
    parameter int GP_LO = 7,
    localparam int IW   = $clog2(N_EV)
) (
    input logic            clk,
    input logic            rst_n,
    input logic            irq_req,
    input logic [IW-1:0]   irq_id,
    input logic            irq_ack,
    input logic            irq_ret,
    input logic            priv,
    input logic            reg_we,
    input logic [N_EV-1:0] lat_q,
    input logic [N_EV-1:0] msk_q,
    input logic [N_EV-1:0] pnd_q,
    input logic            gie_q
);
    p_offer_latched_r5: assert property (@(posedge clk) disable iff (!rst_n)
        irq_req |-> (lat_q[irq_id] && msk_q[irq_id]));

    p_outranks_pending_r7: assert property (@(posedge clk) disable iff (!rst_n)
        irq_req |-> !(|(pnd_q << (N_EV - 1 - int'(irq_id)))));

    p_accept_moves_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_ack && irq_req) |=> (pnd_q[$past(irq_id)] && !lat_q[$past(irq_id)]));

    p_return_pops_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_ret && !(irq_ack && irq_req) && (pnd_q != '0))
        |=> ($countones(pnd_q) + 1 == $countones($past(pnd_q))));

    p_gp_gated_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_req && !gie_q) |-> (int'(irq_id) < GP_LO));

    p_unpriv_mask_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_we && !priv) |=> $stable(msk_q));
endmodule

bind nec_core nec_core_chk #(.N_EV(N_EV), .GP_LO(GP_LO)) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .irq_req (irq_req),
    .irq_id  (irq_id),
    .irq_ack (irq_ack),
    .irq_ret (irq_ret),
    .priv    (priv),
    .reg_we  (reg_we),
    .lat_q   (lat_q),
    .msk_q   (msk_q),
    .pnd_q   (pnd_q),
    .gie_q   (gie_q)
);

// File: tb/sim_nec_core.sv
`timescale 1ns/1ps
module sim_nec_core;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] ev_in = '0;
    logic        irq_req;
    logic [3:0]  irq_id;
    logic        irq_ack = 1'b0;
    logic        irq_ret = 1'b0;
    logic        gie_on = 1'b0;
    logic        gie_off = 1'b0;
    logic        priv = 1'b0;
    logic        reg_we = 1'b0;
    logic [1:0]  reg_addr = 2'd0;
    logic [15:0] reg_wdata = '0;
    logic [15:0] reg_rdata;

    int total = 0;
    int bad = 0;
    bit done = 0;
    string tag = "R1";

    // behavioural reference state
    logic [15:0] m_lat, m_msk, m_pnd;
    bit          m_gie;

    always #2.5 clk = ~clk;

    nec_core u0 (
        .clk(clk), .rst_n(rst_n), .ev_in(ev_in), .irq_req(irq_req), .irq_id(irq_id),
        .irq_ack(irq_ack), .irq_ret(irq_ret), .gie_on(gie_on), .gie_off(gie_off),
        .priv(priv), .reg_we(reg_we), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
        .reg_rdata(reg_rdata)
    );

    function automatic void m_pick(output bit r, output int id);
        int c = -1;
        int p = -1;
        for (int i = 0; i < 16; i++) begin
            if (c < 0 && m_lat[i] && m_msk[i] && (i < 7 || m_gie)) c = i;
            if (p < 0 && m_pnd[i]) p = i;
        end
        r  = (c >= 0) && (p < 0 || c < p);
        id = r ? c : 0;
    endfunction

    function automatic logic [15:0] m_read(logic [1:0] a);
        case (a)
            2'd0: return m_lat;
            2'd1: return m_msk;
            2'd2: return m_pnd;
            default: return 16'h0;
        endcase
    endfunction

    // reference model update on each rising edge from the bench inputs
    always @(posedge clk) begin
        bit r;
        int id;
        if (!rst_n) begin
            m_lat = '0; m_msk = '0; m_pnd = '0; m_gie = 1;
        end else begin
            m_pick(r, id);
            if (reg_we && priv && reg_addr == 2'd0)
                m_lat = (m_lat & m_msk) | (reg_wdata & ~m_msk);
            m_lat = m_lat | ev_in;
            if (irq_ack && r) m_lat[id] = 1'b0;
            if (reg_we && priv && reg_addr == 2'd1) m_msk = reg_wdata;
            if (irq_ret) begin
                for (int i = 0; i < 16; i++) begin
                    if (m_pnd[i]) begin
                        m_pnd[i] = 1'b0;
                        break;
                    end
                end
            end
            if (irq_ack && r) m_pnd[id] = 1'b1;
            if (gie_off) m_gie = 0;
            else if (gie_on) m_gie = 1;
        end
    end

    task automatic chk(bit ok, string t, int act, int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", t, act, exp);
        end
    endtask

    // one cycle: compare against the model at the falling edge, then drop strobes
    task automatic cyc();
        bit r;
        int id;
        @(negedge clk);
        m_pick(r, id);
        chk(irq_req == r, {tag, " irq_req"}, int'(irq_req), int'(r));
        if (r) chk(int'(irq_id) == id, {tag, " irq_id"}, int'(irq_id), id);
        chk(reg_rdata == m_read(reg_addr), {tag, " rdata"}, int'(reg_rdata), int'(m_read(reg_addr)));
        irq_ack = 0; irq_ret = 0; reg_we = 0; gie_on = 0; gie_off = 0;
    endtask

    task automatic rd(logic [1:0] a, logic [15:0] exp, string t);
        reg_addr = a;
        #0.5;
        chk(reg_rdata == exp, t, int'(reg_rdata), int'(exp));
    endtask

    task automatic wr(logic [1:0] a, logic [15:0] d, logic p);
        reg_we = 1; reg_addr = a; reg_wdata = d; priv = p;
        cyc();
    endtask

    task automatic req_is(bit r, int id, string t);
        chk(irq_req == r, t, int'(irq_req), int'(r));
        if (r) chk(int'(irq_id) == id, t, int'(irq_id), id);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        cyc();
        // R1: reset state
        tag = "R1";
        rd(2'd0, 16'h0, "R1 latch"); rd(2'd1, 16'h0, "R1 mask"); rd(2'd2, 16'h0, "R1 pend");
        req_is(0, 0, "R1 no request");
        // R4: unprivileged and pending writes ignored
        tag = "R4";
        wr(2'd1, 16'hFFFF, 0); rd(2'd1, 16'h0, "R4 unpriv mask write");
        wr(2'd2, 16'hFFFF, 1); rd(2'd2, 16'h0, "R4 pend write");
        rd(2'd3, 16'h0, "R4 addr3");
        // R2/R5: capture while masked
        tag = "R2";
        ev_in = 16'h0008; cyc(); ev_in = 0; cyc();
        rd(2'd0, 16'h0008, "R2 latch held");
        req_is(0, 0, "R5 masked not offered");
        // R3: latch writes only on masked positions
        tag = "R3";
        wr(2'd0, 16'h0000, 1); rd(2'd0, 16'h0000, "R3 clear masked");
        wr(2'd1, 16'h0020, 1);
        wr(2'd0, 16'hFFFF, 1); rd(2'd0, 16'hFFDF, "R3 unmasked ignored");
        wr(2'd0, 16'h0000, 1);
        wr(2'd1, 16'hFFFF, 1); rd(2'd1, 16'hFFFF, "R4 priv mask write");
        // R6: priority
        tag = "R6";
        ev_in = 16'h0110; cyc(); ev_in = 0;
        req_is(1, 4, "R6 lowest wins");
        // R8: accept
        tag = "R8";
        irq_ack = 1; cyc();
        rd(2'd2, 16'h0010, "R8 pend set"); rd(2'd0, 16'h0100, "R8 latch cleared");
        req_is(0, 0, "R7 lower priority blocked");
        // R7: nesting of a higher priority event
        tag = "R7";
        ev_in = 16'h0004; cyc(); ev_in = 0;
        req_is(1, 2, "R7 nested offer");
        irq_ack = 1; cyc();
        rd(2'd2, 16'h0014, "R7 nested pend");
        // R9: returns
        tag = "R9";
        irq_ret = 1; cyc(); rd(2'd2, 16'h0010, "R9 pop lowest");
        irq_ret = 1; cyc(); rd(2'd2, 16'h0000, "R9 pop last");
        req_is(1, 8, "R9 waiting event offered");
        // R10: global disable
        tag = "R10";
        gie_off = 1; cyc(); req_is(0, 0, "R10 gp gated");
        ev_in = 16'h0040; cyc(); ev_in = 0;
        req_is(1, 6, "R10 core event unaffected");
        irq_ack = 1; cyc(); irq_ret = 1; cyc();
        req_is(0, 0, "R10 still gated");
        gie_on = 1; gie_off = 1; cyc(); req_is(0, 0, "R10 clear wins");
        gie_on = 1; cyc(); req_is(1, 8, "R10 re-enabled");
        // R8: accept beats same-cycle capture
        tag = "R8";
        ev_in = 16'h0100; irq_ack = 1; cyc(); ev_in = 0;
        rd(2'd0, 16'h0000, "R8 clear beats capture"); rd(2'd2, 16'h0100, "R8 pend 8");
        irq_ret = 1; cyc();
        // R5/R6/R9: random stretch against the model
        tag = "R5 random";
        for (int n = 0; n < 4000; n++) begin
            ev_in   = 16'($urandom & $urandom & $urandom & $urandom);
            irq_ack = ($urandom % 3) == 0;
            irq_ret = ($urandom % 5) == 0;
            gie_off = ($urandom % 40) == 0;
            gie_on  = ($urandom % 40) == 0;
            reg_we  = ($urandom % 12) == 0;
            priv    = $urandom % 2;
            reg_addr  = 2'($urandom);
            reg_wdata = 16'($urandom);
            cyc();
        end
        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    // watchdog
    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule